// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

This block is the integer execution unit of a small in-order datapath. It takes two operands and a 4-bit operation select and returns one result word with two flags: a carry for the unsigned add and subtract operations and an overflow for the signed ones. It handles add and subtract in signed and unsigned forms, the four bitwise operations AND, OR, XOR and NOR, and signed and unsigned compare-less-than. Immediate operands are assumed to be sign or zero extended before they reach the block.

The sum is formed by a ripple chain of one-bit full-adder slices. Subtraction inverts the second operand and forces the chain's carry-in to one. Both compare operations reuse that subtract path. The signed compare takes the difference's sign corrected by the overflow, and the unsigned compare takes the borrow. The result and flags are captured in output registers, so each operation completes one clock after its inputs are sampled.

Top module: `int_alu`

## Requirements
- R1: While `rst_n` is low, `res_q`, `carry_q` and `ovf_q` are all 0 whatever the inputs are.
- R2: The outputs present the operation of the inputs sampled at the previous rising clock edge. Between edges they hold their value even when the inputs change.
- R3: Select 0 (signed add) and select 2 (signed subtract) give A+B and A-B modulo 2^WIDTH. `ovf_q` is 1 exactly when the true signed result does not fit, and `carry_q` is 0.
- R4: Select 1 (unsigned add) and select 3 (unsigned subtract) give A+B and A-B modulo 2^WIDTH, with `ovf_q` 0. `carry_q` is the carry out of the top slice. For an add this is the unsigned wrap. For a subtract it is 1 when A >= B, meaning no borrow.
- R5: Selects 4, 5, 6 and 7 give bitwise AND, OR, XOR and NOR of A and B, with both flags 0.
- R6: Select 10 gives 1 when A < B as two's-complement numbers and 0 otherwise. This also holds when A-B overflows. Both flags are 0.
- R7: Select 11 gives 1 when A < B as unsigned numbers and 0 otherwise, with both flags 0.
- R8: Selects 8, 9 and 12 to 15 give a result of 0 with both flags 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| opd_a | input | WIDTH | First operand |
| opd_b | input | WIDTH | Second operand (subtrahend for subtract and compare) |
| op_sel | input | 4 | Operation select, codes as in R3 to R8 |
| res_q | output | WIDTH | Registered result |
| carry_q | output | 1 | Registered unsigned carry or no-borrow flag |
| ovf_q | output | 1 | Registered signed overflow flag |

## Verification
The bench uses the default WIDTH of 32. At that width the two most negative and positive operands, all-ones words and the sign bit at position 31 all come up in the directed vectors. This covers overflow on both add and subtract and the carry wrap of the unsigned forms. It also covers the compare case where A-B overflows and a plain sign test would give the wrong answer. Every select code, including the six unused ones, is applied at least once.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] opd_a,
  input  logic [WIDTH-1:0] opd_b,
  input  logic [3:0]       op_sel,
  output logic [WIDTH-1:0] res_q,
  output logic             carry_q,
  output logic             ovf_q
);

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADDU = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_SUBU = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4;
  localparam logic [3:0] OP_OR   = 4'd5;
  localparam logic [3:0] OP_XOR  = 4'd6;
  localparam logic [3:0] OP_NOR  = 4'd7;
  localparam logic [3:0] OP_SLT  = 4'd10;
  localparam logic [3:0] OP_SLTU = 4'd11;
  localparam int         MSB     = WIDTH - 1;

  logic             negate;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic [WIDTH:0]   cy;
  logic             v_raw;

  assign negate = (op_sel == OP_SUB) || (op_sel == OP_SUBU) ||
                  (op_sel == OP_SLT) || (op_sel == OP_SLTU);
  assign b_eff  = opd_b ^ {WIDTH{negate}};
  assign cy[0]  = negate;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic p;
    assign p         = opd_a[i] ^ b_eff[i];
    assign sum[i]    = p ^ cy[i];
    assign cy[i+1]   = (opd_a[i] & b_eff[i]) | (p & cy[i]);
  end

  assign v_raw = cy[MSB] ^ cy[WIDTH];

  logic [WIDTH-1:0] res_d;
  logic             carry_d;
  logic             ovf_d;

  always_comb begin
    res_d   = '0;
    carry_d = 1'b0;
    ovf_d   = 1'b0;
    case (op_sel)
      OP_ADD, OP_SUB: begin
        res_d = sum;
        ovf_d = v_raw;
      end
      OP_ADDU, OP_SUBU: begin
        res_d   = sum;
        carry_d = cy[WIDTH];
      end
      OP_AND:  res_d = opd_a & opd_b;
      OP_OR:   res_d = opd_a | opd_b;
      OP_XOR:  res_d = opd_a ^ opd_b;
      OP_NOR:  res_d = (opd_a | opd_b) ^ {WIDTH{1'b1}};
      OP_SLT:  res_d = {{(WIDTH-1){1'b0}}, sum[MSB] ^ v_raw};
      OP_SLTU: res_d = {{(WIDTH-1){1'b0}}, ~cy[WIDTH]};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q   <= '0;
      carry_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      res_q   <= res_d;
      carry_q <= carry_d;
      ovf_q   <= ovf_d;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(!rst_n) |-> (res_q == '0 && !carry_q && !ovf_q));

  a_r3_ovf_signed_only: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> ($past(op_sel) == OP_ADD || $past(op_sel) == OP_SUB));

  a_r4_carry_unsigned_only: assert property (@(posedge clk) disable iff (!rst_n)
    carry_q |-> ($past(op_sel) == OP_ADDU || $past(op_sel) == OP_SUBU));

  a_r3_add_ovf_same_sign: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_sel) == OP_ADD && $past(opd_a[MSB]) != $past(opd_b[MSB])) |-> !ovf_q);

  a_r6_slt_boolean: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_sel) == OP_SLT || $past(op_sel) == OP_SLTU) |-> (res_q[MSB:1] == '0));

  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_sel) == 4'd8 || $past(op_sel) == 4'd9 || $past(op_sel) >= 4'd12)
      |-> (res_q == '0 && !carry_q && !ovf_q));

endmodule

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;

  localparam int W = 32;
  localparam int NV = 34;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [3:0]   op = '0;
  logic [W-1:0] res_q;
  logic         carry_q;
  logic         ovf_q;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  int_alu #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .opd_a(a), .opd_b(b), .op_sel(op),
    .res_q(res_q), .carry_q(carry_q), .ovf_q(ovf_q)
  );

  // {op, a, b}
  localparam logic [67:0] VEC [NV] = '{
    {4'd0,  32'h0000_0005, 32'hFFFF_FFFD},
    {4'd0,  32'h7FFF_FFFF, 32'h0000_0001},
    {4'd0,  32'h8000_0000, 32'hFFFF_FFFF},
    {4'd0,  32'h7FFF_FFFF, 32'h8000_0000},
    {4'd1,  32'hFFFF_FFFF, 32'h0000_0001},
    {4'd1,  32'h1234_5678, 32'h0000_1111},
    {4'd1,  32'h7FFF_FFFF, 32'h0000_0001},
    {4'd2,  32'h8000_0000, 32'h0000_0001},
    {4'd2,  32'h7FFF_FFFF, 32'hFFFF_FFFF},
    {4'd2,  32'h0000_0003, 32'h0000_0007},
    {4'd3,  32'h0000_0000, 32'h0000_0001},
    {4'd3,  32'h0000_0005, 32'h0000_0005},
    {4'd3,  32'h8000_0000, 32'h0000_0001},
    {4'd4,  32'hF0F0_F0F0, 32'hFF00_FF00},
    {4'd5,  32'hF0F0_F0F0, 32'h0F00_0F0F},
    {4'd6,  32'hAAAA_5555, 32'hFFFF_0000},
    {4'd7,  32'h0000_0000, 32'h0000_0000},
    {4'd7,  32'h1234_0000, 32'h0000_00F0},
    {4'd10, 32'hFFFF_FFFF, 32'h0000_0001},
    {4'd11, 32'hFFFF_FFFF, 32'h0000_0001},
    {4'd10, 32'h7FFF_FFFF, 32'h8000_0000},
    {4'd11, 32'h7FFF_FFFF, 32'h8000_0000},
    {4'd10, 32'h8000_0000, 32'h7FFF_FFFF},
    {4'd10, 32'h0000_0009, 32'h0000_0009},
    {4'd11, 32'h0000_0009, 32'h0000_0009},
    {4'd11, 32'h0000_0000, 32'hFFFF_FFFF},
    {4'd10, 32'hFFFF_FFFE, 32'hFFFF_FFFF},
    {4'd8,  32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {4'd9,  32'h7FFF_FFFF, 32'h0000_0001},
    {4'd12, 32'hFFFF_FFFF, 32'h0000_0001},
    {4'd13, 32'h1234_5678, 32'h8765_4321},
    {4'd14, 32'h8000_0000, 32'h8000_0000},
    {4'd15, 32'hFFFF_FFFF, 32'h0000_0000},
    {4'd0,  32'h8000_0000, 32'h8000_0000}
  };

  function automatic logic [W+1:0] model(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] r;
    logic c, v;
    logic [W:0] wide;
    r = '0; c = 1'b0; v = 1'b0;
    case (o)
      4'd0: begin r = x + y; v = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]); end
      4'd1: begin wide = {1'b0, x} + {1'b0, y}; r = wide[W-1:0]; c = wide[W]; end
      4'd2: begin r = x - y; v = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]); end
      4'd3: begin r = x - y; c = (x >= y); end
      4'd4: r = x & y;
      4'd5: r = x | y;
      4'd6: r = x ^ y;
      4'd7: r = ~(x | y);
      4'd10: r = ($signed(x) < $signed(y)) ? 1 : 0;
      4'd11: r = (x < y) ? 1 : 0;
      default: ;
    endcase
    return {r, c, v};
  endfunction

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd2: return "R3";
      4'd1, 4'd3: return "R4";
      4'd4, 4'd5, 4'd6, 4'd7: return "R5";
      4'd10: return "R6";
      4'd11: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string rq, input logic [W+1:0] exp);
    n_chk++;
    if ({res_q, carry_q, ovf_q} !== exp) begin
      n_bad++;
      $display("FAIL %s: op=%0d a=%h b=%h got res=%h c=%b v=%b exp res=%h c=%b v=%b",
               rq, op, a, b, res_q, carry_q, ovf_q, exp[W+1:2], exp[1], exp[0]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles exp < 20000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [W+1:0] prev;
    // R1: outputs held at zero while reset is low, inputs active
    a = 32'h7FFF_FFFF; b = 32'h1; op = 4'd0;
    repeat (3) @(negedge clk);
    check("R1", '0);

    @(negedge clk) rst_n = 1'b1;

    foreach (VEC[i]) begin
      op = VEC[i][67:64]; a = VEC[i][63:32]; b = VEC[i][31:0];
      @(negedge clk);
      check(req_of(op), model(op, a, b));
    end

    // R2: outputs keep last result when inputs change between edges
    op = 4'd1; a = 32'hFFFF_FFFF; b = 32'h2;
    @(negedge clk);
    prev = model(4'd1, 32'hFFFF_FFFF, 32'h2);
    op = 4'd4; a = 32'h0; b = 32'h0;
    #2;
    check("R2", prev);
    @(negedge clk);
    check("R2", model(4'd4, 32'h0, 32'h0));

    // R1: reset mid-run clears registered outputs
    op = 4'd2; a = 32'h8000_0000; b = 32'h1;
    @(negedge clk);
    check("R3", model(4'd2, a, b));
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3", model(4'd2, a, b));

    // R6/R7 back-to-back on same operands where sign test alone would differ
    op = 4'd10; a = 32'h8000_0000; b = 32'h0000_0001;
    @(negedge clk);
    check("R6", {32'd1, 2'b00});
    op = 4'd11;
    @(negedge clk);
    check("R7", {32'd0, 2'b00});

    finish_run();
  end

endmodule